// File: doc/BRIEF.md
# Pulse-Gap Transponder Write Encoder

This block drives one field-control line to program a low-frequency transponder. Every bit takes a slot of fixed length. The slot starts with the reader field switched off for a short or a long gap and ends with the field switched back on for the rest of the slot. The length of the gap gives the bit value. One start strobe runs a whole command with no further input. The field is held on first to charge the tag. Then a fixed two-byte header goes out, then the 64-bit payload, the 16-bit check word and a fixed two-byte trailer. Last, the field stays on for a programming hold while the tag commits the data.

All timing is counted in microseconds. The microseconds come from a clock-enable tick, and `CYC_PER_US` enabled ticks make one microsecond. The block latches the payload and check inputs when it accepts the start strobe. It does not compute the check word; the caller supplies it.

Top module: `pgw_write_encoder`

## Requirements
- R1: After reset, `field_on` is 1, `busy` is 0 and `done` is 0. The block stays in that state until a start strobe arrives.
- R2: A start strobe sampled while idle raises `busy` on the next cycle. The field then stays on for `CHARGE_US` microseconds before the first gap.
- R3: A 1 bit is the field off for `ONE_OFF_US`, then on for `ONE_ON_US` (defaults 1000 us and 1000 us).
- R4: A 0 bit is the field off for `ZERO_OFF_US`, then on for `ZERO_ON_US` (defaults 300 us and 1700 us).
- R5: The 14 bytes go out in this order: 0xBB, 0xEB, payload bits [7:0] up to [63:56], check bits [7:0], check bits [15:8], 0x00, 0x03.
- R6: Within each byte, bit 0 goes out first and bit 7 last.
- R7: After the last bit the field stays on and `busy` stays high for `HOLD_US` microseconds.
- R8: At the end of the hold, `done` is high for exactly one cycle. In that same cycle `busy` is low and `field_on` is 1, and both keep those values afterwards.
- R9: A start strobe that arrives while `busy` is high has no effect on the waveform or on its length.
- R10: Time advances only on cycles where `tick_en` is high. One microsecond is `CYC_PER_US` enabled cycles, and a cycle with `tick_en` low freezes the output.
- R11: The payload and check inputs are captured on the accepted start strobe. Changing them during a command does not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Clock-enable tick; `CYC_PER_US` of them make one microsecond |
| start | input | 1 | Start strobe, accepted only when idle |
| data_i | input | 64 | Payload, sent from the low byte up |
| chk_i | input | 16 | Check word, sent low byte first |
| field_on | output | 1 | 1 = reader field on, 0 = field off |
| busy | output | 1 | High from the cycle after the accepted start until the hold ends |
| done | output | 1 | One-cycle pulse when the hold ends |

## Verification
The bench runs the encoder on short durations. It uses distinct off lengths for the two bit values, with equal slot totals, so that a swap of the 1 and 0 encodings cannot go unseen. It compares every cycle of the field, `busy` and `done` against a tick-count model. The payloads are zeros, ones, a mixed hex value and a walking pattern. Together they separate a wrong byte order, a reversed bit order and a stuck or swapped header or trailer. A run with `tick_en` high one cycle in three tells correct tick gating from free-running counters. Runs with a start strobe and with changed inputs in the middle of a command show whether a restart or a failure to latch the inputs corrupts the frame.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  localparam int DATA_W      = 64;
  localparam int CHK_W       = 16;
  localparam int HEAD_BYTES  = 2;
  localparam int TAIL_BYTES  = 2;
  localparam int FRAME_BYTES = HEAD_BYTES + DATA_W / 8 + CHK_W / 8 + TAIL_BYTES;
  localparam int FRAME_W     = FRAME_BYTES * 8;

  localparam logic [7:0] KEY_BYTE  = 8'hBB;
  localparam logic [7:0] PASS_BYTE = 8'hEB;
  localparam logic [7:0] TRAIL_LO  = 8'h00;
  localparam logic [7:0] TRAIL_HI  = 8'h03;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CHARGE,
    PH_GAP,
    PH_MARK,
    PH_HOLD
  } phase_e;

  typedef enum logic [2:0] {
    LEN_CHARGE,
    LEN_OFF1,
    LEN_ON1,
    LEN_OFF0,
    LEN_ON0,
    LEN_HOLD
  } len_sel_e;

endpackage

// File: rtl/pgw_phase_timer.sv
module pgw_phase_timer #(
  parameter int CYC_PER_US = 125,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             restart,
  input  logic [LEN_W-1:0] len_us,
  output logic             phase_end
);

  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [LEN_W-1:0] us_q, us_d;
  logic             adv;
  logic             us_wrap;

  assign adv       = run && tick_en;
  assign us_wrap   = adv && (pre_q == PRE_LAST);
  assign phase_end = us_wrap && (us_q == (len_us - 1'b1));

  always_comb begin
    pre_d = pre_q;
    us_d  = us_q;
    if (restart) begin
      pre_d = '0;
      us_d  = '0;
    end else if (adv) begin
      if (pre_q == PRE_LAST) begin
        pre_d = '0;
        us_d  = phase_end ? '0 : us_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else begin
      pre_q <= pre_d;
      us_q  <= us_d;
    end
  end

endmodule

// File: rtl/pgw_frame_reg.sv
module pgw_frame_reg
  import pgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic              cur_bit
);

  localparam int DATA_OFS = HEAD_BYTES * 8;
  localparam int CHK_OFS  = DATA_OFS + DATA_W;
  localparam int TAIL_OFS = CHK_OFS + CHK_W;

  logic [FRAME_W-1:0] frame_img;
  logic [FRAME_W-1:0] frame_q, frame_d;

  assign frame_img[7:0]  = KEY_BYTE;
  assign frame_img[15:8] = PASS_BYTE;

  for (genvar b = 0; b < DATA_W / 8; b++) begin : g_data_byte
    assign frame_img[DATA_OFS + 8*b +: 8] = data_i[8*b +: 8];
  end

  for (genvar c = 0; c < CHK_W / 8; c++) begin : g_chk_byte
    assign frame_img[CHK_OFS + 8*c +: 8] = chk_i[8*c +: 8];
  end

  assign frame_img[TAIL_OFS +: 8]     = TRAIL_LO;
  assign frame_img[TAIL_OFS + 8 +: 8] = TRAIL_HI;

  always_comb begin
    frame_d = frame_q;
    if (load) begin
      frame_d = frame_img;
    end else if (shift) begin
      frame_d = {1'b0, frame_q[FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else begin
      frame_q <= frame_d;
    end
  end

  assign cur_bit = frame_q[0];

endmodule

// File: rtl/pgw_sequencer.sv
module pgw_sequencer
  import pgw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     phase_end,
  input  logic     cur_bit,
  output phase_e   phase,
  output len_sel_e len_sel,
  output logic     load,
  output logic     shift,
  output logic     restart,
  output logic     done
);

  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             last_bit;

  assign last_bit = (cnt_q == LAST_BIT);

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    load    = 1'b0;
    shift   = 1'b0;
    restart = 1'b0;
    len_sel = LEN_CHARGE;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d    = PH_CHARGE;
          cnt_d   = '0;
          load    = 1'b1;
          restart = 1'b1;
        end
      end
      PH_CHARGE: begin
        len_sel = LEN_CHARGE;
        if (phase_end) ph_d = PH_GAP;
      end
      PH_GAP: begin
        len_sel = cur_bit ? LEN_OFF1 : LEN_OFF0;
        if (phase_end) ph_d = PH_MARK;
      end
      PH_MARK: begin
        len_sel = cur_bit ? LEN_ON1 : LEN_ON0;
        if (phase_end) begin
          if (last_bit) begin
            ph_d = PH_HOLD;
          end else begin
            ph_d  = PH_GAP;
            shift = 1'b1;
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_HOLD: begin
        len_sel = LEN_HOLD;
        if (phase_end) begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign phase = ph_q;
  assign done  = done_q;

endmodule

// File: rtl/pgw_write_encoder.sv
module pgw_write_encoder
  import pgw_pkg::*;
#(
  parameter int CYC_PER_US  = 125,
  parameter int ONE_OFF_US  = 1000,
  parameter int ONE_ON_US   = 1000,
  parameter int ZERO_OFF_US = 300,
  parameter int ZERO_ON_US  = 1700,
  parameter int CHARGE_US   = 50000,
  parameter int HOLD_US     = 50000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        start,
  input  logic [63:0] data_i,
  input  logic [15:0] chk_i,
  output logic        field_on,
  output logic        busy,
  output logic        done
);

  localparam int MAX_A  = (ONE_OFF_US > ONE_ON_US) ? ONE_OFF_US : ONE_ON_US;
  localparam int MAX_B  = (ZERO_OFF_US > ZERO_ON_US) ? ZERO_OFF_US : ZERO_ON_US;
  localparam int MAX_C  = (CHARGE_US > HOLD_US) ? CHARGE_US : HOLD_US;
  localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_US = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int LEN_W  = $clog2(MAX_US + 1);

  phase_e           phase;
  len_sel_e         len_sel;
  logic [LEN_W-1:0] len_us;
  logic             load, shift, restart, phase_end, cur_bit, run;

  always_comb begin
    unique case (len_sel)
      LEN_CHARGE: len_us = LEN_W'(CHARGE_US);
      LEN_OFF1:   len_us = LEN_W'(ONE_OFF_US);
      LEN_ON1:    len_us = LEN_W'(ONE_ON_US);
      LEN_OFF0:   len_us = LEN_W'(ZERO_OFF_US);
      LEN_ON0:    len_us = LEN_W'(ZERO_ON_US);
      LEN_HOLD:   len_us = LEN_W'(HOLD_US);
      default:    len_us = LEN_W'(HOLD_US);
    endcase
  end

  assign run = (phase != PH_IDLE);

  pgw_phase_timer #(
    .CYC_PER_US (CYC_PER_US),
    .LEN_W      (LEN_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .run       (run),
    .restart   (restart),
    .len_us    (len_us),
    .phase_end (phase_end)
  );

  pgw_frame_reg u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .shift   (shift),
    .data_i  (data_i),
    .chk_i   (chk_i),
    .cur_bit (cur_bit)
  );

  pgw_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .phase_end (phase_end),
    .cur_bit   (cur_bit),
    .phase     (phase),
    .len_sel   (len_sel),
    .load      (load),
    .shift     (shift),
    .restart   (restart),
    .done      (done)
  );

  assign field_on = (phase != PH_GAP);
  assign busy     = run;

endmodule

// File: rtl/pgw_write_encoder_chk.sv
module pgw_write_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic start,
  input logic field_on,
  input logic busy,
  input logic done
);

  assert_idle_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> field_on);

  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && field_on));

  assert_gap_inside_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !field_on |-> busy);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && field_on && $past(busy)));

  assert_stall_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_en) |=> (busy && $stable(field_on)));

endmodule

bind pgw_write_encoder pgw_write_encoder_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .start    (start),
  .field_on (field_on),
  .busy     (busy),
  .done     (done)
);

// File: tb/tb_pgw_write_encoder.sv
module tb_pgw_write_encoder;

  localparam int CYC    = 2;
  localparam int OFF1   = 3;
  localparam int ON1    = 3;
  localparam int OFF0   = 1;
  localparam int ON0    = 5;
  localparam int CHG    = 7;
  localparam int HLD    = 9;
  localparam int NBYTES = 14;
  localparam int NBITS  = NBYTES * 8;

  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        start;
  logic [63:0] data_i;
  logic [15:0] chk_i;
  logic        field_on;
  logic        busy;
  logic        done;

  int checks = 0;
  int fails  = 0;

  pgw_write_encoder #(
    .CYC_PER_US  (CYC),
    .ONE_OFF_US  (OFF1),
    .ONE_ON_US   (ON1),
    .ZERO_OFF_US (OFF0),
    .ZERO_ON_US  (ON0),
    .CHARGE_US   (CHG),
    .HOLD_US     (HLD)
  ) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .start    (start),
    .data_i   (data_i),
    .chk_i    (chk_i),
    .field_on (field_on),
    .busy     (busy),
    .done     (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected byte k of the command (R5 order)
  function automatic logic [7:0] cmd_byte(input int k, input logic [63:0] d,
                                          input logic [15:0] c);
    if (k == 0)       return 8'hBB;
    else if (k == 1)  return 8'hEB;
    else if (k <= 9)  return d[8*(k-2) +: 8];
    else if (k == 10) return c[7:0];
    else if (k == 11) return c[15:8];
    else if (k == 12) return 8'h00;
    else              return 8'h03;
  endfunction

  function automatic bit cmd_bit(input int i, input logic [63:0] d, input logic [15:0] c);
    logic [7:0] b;
    b = cmd_byte(i / 8, d, c);
    return b[i % 8];
  endfunction

  // Phase code after t enabled ticks: 0 charge, 1 gap of 1, 2 on of 1,
  // 3 gap of 0, 4 on of 0, 5 hold, 6 finished
  function automatic int model(input int t, input logic [63:0] d, input logic [15:0] c);
    int r;
    r = t;
    if (r < CHG * CYC) return 0;
    r -= CHG * CYC;
    for (int i = 0; i < NBITS; i++) begin
      bit v;
      int off_len, on_len;
      v = cmd_bit(i, d, c);
      off_len = (v ? OFF1 : OFF0) * CYC;
      on_len  = (v ? ON1 : ON0) * CYC;
      if (r < off_len) return v ? 1 : 3;
      r -= off_len;
      if (r < on_len) return v ? 2 : 4;
      r -= on_len;
    end
    if (r < HLD * CYC) return 5;
    return 6;
  endfunction

  function automatic string tag_of(input int code);
    case (code)
      0:       return "R2";
      1, 2:    return "R3";
      3, 4:    return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic run_cmd(input logic [63:0] d, input logic [15:0] c, input int tick_div,
                         input bit poke_start, input bit swap_inputs);
    int  t, cyc, code, run_len, nb, fails_before, mid;
    bit  obs[NBITS];
    string req;
    fails_before = 0;
    for (int i = 0; i < NBITS; i++) obs[i] = 1'b0;
    @(negedge clk);
    data_i  = d;
    chk_i   = c;
    start   = 1'b1;
    tick_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    fails_before = fails;
    t = 0; cyc = 0; run_len = 0; nb = 0;
    mid = model(0, d, c);
    while (1) begin
      code = model(t, d, c);
      if (code == 6) begin
        check(done === 1'b1,     "R8", "done at hold end", done, 1);
        check(busy === 1'b0,     "R8", "busy at hold end", busy, 0);
        check(field_on === 1'b1, "R8", "field at hold end", field_on, 1);
        break;
      end
      req = (tick_div > 1) ? "R10" : tag_of(code);
      check(busy === 1'b1, req, "busy during command", busy, 1);
      check(field_on === ((code == 1 || code == 3) ? 1'b0 : 1'b1), req, "field level",
            field_on, (code == 1 || code == 3) ? 0 : 1);
      check(done === 1'b0, req, "done during command", done, 0);
      if (tick_div == 1) begin
        if (field_on === 1'b0) begin
          run_len++;
        end else if (run_len > 0) begin
          if (nb < NBITS) obs[nb] = (run_len == OFF1 * CYC);
          nb++;
          run_len = 0;
        end
      end
      tick_en = ((cyc % tick_div) == 0);
      cyc++;
      start = poke_start && (t >= 700) && (t < 706);
      if (swap_inputs && t == 500) begin
        data_i = ~d;
        chk_i  = ~c;
      end
      @(posedge clk);
      if (tick_en) t++;
      @(negedge clk);
    end
    start   = 1'b0;
    tick_en = 1'b1;
    if (poke_start)
      check(fails == fails_before, "R9", "start while busy changed command",
            64'(fails - fails_before), 0);
    if (swap_inputs)
      check(fails == fails_before, "R11", "mid-command input change altered frame",
            64'(fails - fails_before), 0);
    if (tick_div == 1) begin
      check(nb == NBITS, "R5", "gap count", 64'(nb), 64'(NBITS));
      for (int k = 0; k < NBYTES; k++) begin
        logic [7:0] got;
        for (int j = 0; j < 8; j++) got[j] = obs[8*k + j];
        check(got === cmd_byte(k, d, c), "R5 R6", $sformatf("decoded byte %0d", k),
              64'(got), 64'(cmd_byte(k, d, c)));
      end
    end
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0 && field_on === 1'b1, "R8",
          "state after done", {61'd0, done, busy, field_on}, 64'b001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    tick_en = 1'b0;
    start   = 1'b0;
    data_i  = '0;
    chk_i   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(field_on === 1'b1, "R1", "field after reset", field_on, 1);
    check(busy === 1'b0,     "R1", "busy after reset", busy, 0);
    check(done === 1'b0,     "R1", "done after reset", done, 0);
    tick_en = 1'b1;
    repeat (20) @(negedge clk);
    check(busy === 1'b0 && field_on === 1'b1, "R1", "idle without start",
          {62'd0, busy, field_on}, 64'b01);

    run_cmd(64'h0123_4567_89AB_CDEF, 16'hBEEF, 1, 1'b0, 1'b0);
    run_cmd(64'h0, 16'h0, 1, 1'b0, 1'b0);
    run_cmd(64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 1, 1'b0, 1'b0);
    run_cmd(64'h8040_2010_0804_0201, 16'h8001, 1, 1'b1, 1'b0);
    run_cmd(64'hA5C3_5A3C_0FF0_1E2D, 16'h1234, 1, 1'b0, 1'b1);
    run_cmd(64'hDEAD_BEEF_CAFE_F00D, 16'h55AA, 3, 1'b1, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule